// File: doc/BRIEF.md
# Dynamic Phase-Tap Step Controller

This block keeps the phase-tap indices of a clock synthesizer's counters and changes them one step at a time while the clocks keep running. There is one index for the feedback counter and one for each output counter. Every index is a 3-bit value that selects one of eight oscillator phase taps, spaced one eighth of the oscillator period apart. A step never goes through a serial reconfiguration chain.

User logic sets a 4-bit counter select and a direction bit, then raises a step strobe. All three are sampled on the rising edge of the scan clock. The rising edge of the strobe starts one step. The done output goes low while the step is applied and comes back high in the same cycle that the new tap value appears. One select code sends the step to every output counter together. The oscillator and the phase multiplexers are outside the block. Its tap indices are outputs that the clock muxing, or a testbench, reads.

Top module: `phase_step_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, every tap index is 0 and done is 1.
- R2: A step with select code 1 moves only the feedback tap. No output tap changes.
- R3: A step with select code 2+i (i from 0 to 9) moves only output tap i, at bits [3i+2:3i] of tap_out. The feedback tap does not change.
- R4: A step with select code 0 moves all ten output taps by one position in the same cycle. The feedback tap does not change.
- R5: A step with select code 12, 13, 14 or 15 changes no tap. done still goes low and comes back high as for any other step.
- R6: When step_dir is 1 the selected tap goes up by one and wraps from 7 to 0. When step_dir is 0 it goes down by one and wraps from 0 to 7.
- R7: Each rising edge of step_req applies exactly one step. If step_req stays high, no further step is applied until it has gone low and risen again.
- R8: Suppose step_req is first sampled high at scan-clock edge k while done is 1. Then done is 0 after edge k+1 and stays 0 through edge k+SETTLE. At edge k+1+SETTLE the tap changes and done returns to 1. With the default SETTLE = 2, the tap changes at edge k+3.
- R9: A rising edge of step_req that is sampled while done is 0 is ignored. It gives no step, now or later.
- R10: The select code and direction used for a step are the values sampled at the same edge where step_req was first sampled high. Changes to them after that edge do not affect the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_sel | input | 4 | Counter select: 0 = all output counters, 1 = feedback, 2..11 = output 0..9 |
| step_dir | input | 1 | Step direction: 1 = up, 0 = down |
| step_req | input | 1 | Step strobe; its rising edge requests one step |
| done | output | 1 | High when idle; low while a step is in progress |
| tap_fb | output | 3 | Phase-tap index of the feedback counter |
| tap_out | output | 30 | Phase-tap indices of output counters 0..9, three bits each, counter 0 in the low bits |

## Verification
Take edge k as the edge where the strobe is first sampled high. Then done falls one edge after k, and both the tap change and the rise of done come SETTLE+1 edges after k. An edge-accurate reference model in the bench moves its own tap array at exactly that edge. The bench compares done and every tap with the model at each falling edge, half a period after the registers update, so each result is checked in the cycle it is due. Stimulus changes only on falling edges. Directed checks then read the absolute tap values after each scenario, and one scenario tracks done edge by edge through a single step.

// File: rtl/phstep_pkg.sv
package phstep_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;

  localparam int SEL_CODE_ALL_OUT = 0;
  localparam int SEL_CODE_FB      = 1;
  localparam int SEL_CODE_OUT0    = 2;

endpackage

// File: rtl/phstep_in_reg.sv
module phstep_in_reg #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic [SEL_W-1:0] cnt_sel,
  input  logic             step_dir,
  output logic [SEL_W-1:0] sel_q,
  output logic             dir_q,
  output logic             req_rise
);

  logic             req_q, req_prev_q;
  logic             req_d, req_prev_d;
  logic [SEL_W-1:0] sel_d;
  logic             dir_d;

  always_comb begin
    req_d      = step_req;
    req_prev_d = req_q;
    sel_d      = cnt_sel;
    dir_d      = step_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      req_prev_q <= 1'b0;
      sel_q      <= '0;
      dir_q      <= 1'b0;
    end else begin
      req_q      <= req_d;
      req_prev_q <= req_prev_d;
      sel_q      <= sel_d;
      dir_q      <= dir_d;
    end
  end

  assign req_rise = req_q & ~req_prev_q;

endmodule

// File: rtl/phstep_seq.sv
module phstep_seq
  import phstep_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rise,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             dir_q,
  output logic             apply,
  output logic [SEL_W-1:0] cmd_sel,
  output logic             cmd_dir,
  output logic             done
);

  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] cmd_sel_d;
  logic             cmd_dir_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cmd_sel_d = cmd_sel;
    cmd_dir_d = cmd_dir;
    apply     = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (req_rise) begin
          state_d   = SEQ_BUSY;
          cnt_d     = CNT_W'(SETTLE - 1);
          cmd_sel_d = sel_q;
          cmd_dir_d = dir_q;
        end
      end
      SEQ_BUSY: begin
        if (cnt_q == '0) begin
          apply   = 1'b1;
          state_d = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      cmd_sel <= '0;
      cmd_dir <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_sel <= cmd_sel_d;
      cmd_dir <= cmd_dir_d;
    end
  end

  assign done = (state_q == SEQ_IDLE);

endmodule

// File: rtl/phstep_tap_bank.sv
module phstep_tap_bank
  import phstep_pkg::*;
#(
  parameter int NUM_OUT = 10,
  parameter int TAP_W   = 3,
  parameter int SEL_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     apply,
  input  logic [SEL_W-1:0]         cmd_sel,
  input  logic                     cmd_dir,
  output logic [TAP_W-1:0]         tap_fb,
  output logic [NUM_OUT*TAP_W-1:0] tap_out
);

  localparam logic [SEL_W-1:0] CODE_ALL = SEL_W'(SEL_CODE_ALL_OUT);
  localparam logic [SEL_W-1:0] CODE_FB  = SEL_W'(SEL_CODE_FB);

  // Feedback counter tap
  logic             fb_hit;
  logic [TAP_W-1:0] fb_q, fb_d;

  always_comb begin
    fb_hit = apply && (cmd_sel == CODE_FB);
    fb_d   = fb_q;
    if (fb_hit) fb_d = cmd_dir ? fb_q + TAP_W'(1) : fb_q - TAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= '0;
    else        fb_q <= fb_d;
  end

  assign tap_fb = fb_q;

  // Output counter taps
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam logic [SEL_W-1:0] CODE_ME = SEL_W'(SEL_CODE_OUT0 + i);
    logic             hit;
    logic [TAP_W-1:0] t_q, t_d;

    always_comb begin
      hit = apply && ((cmd_sel == CODE_ALL) || (cmd_sel == CODE_ME));
      t_d = t_q;
      if (hit) t_d = cmd_dir ? t_q + TAP_W'(1) : t_q - TAP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t_q <= '0;
      else        t_q <= t_d;
    end

    assign tap_out[i*TAP_W +: TAP_W] = t_q;
  end

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int NUM_OUT = 10,
  parameter int TAP_W   = 3,
  parameter int SEL_W   = 4,
  parameter int SETTLE  = 2
) (
  input  logic                     scan_clk,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         cnt_sel,
  input  logic                     step_dir,
  input  logic                     step_req,
  output logic                     done,
  output logic [TAP_W-1:0]         tap_fb,
  output logic [NUM_OUT*TAP_W-1:0] tap_out
);

  logic [SEL_W-1:0] sel_q, cmd_sel;
  logic             dir_q, cmd_dir, req_rise, apply;

  phstep_in_reg #(.SEL_W(SEL_W)) u_in (
    .clk      (scan_clk),
    .rst_n    (rst_n),
    .step_req (step_req),
    .cnt_sel  (cnt_sel),
    .step_dir (step_dir),
    .sel_q    (sel_q),
    .dir_q    (dir_q),
    .req_rise (req_rise)
  );

  phstep_seq #(.SEL_W(SEL_W), .SETTLE(SETTLE)) u_seq (
    .clk      (scan_clk),
    .rst_n    (rst_n),
    .req_rise (req_rise),
    .sel_q    (sel_q),
    .dir_q    (dir_q),
    .apply    (apply),
    .cmd_sel  (cmd_sel),
    .cmd_dir  (cmd_dir),
    .done     (done)
  );

  phstep_tap_bank #(.NUM_OUT(NUM_OUT), .TAP_W(TAP_W), .SEL_W(SEL_W)) u_taps (
    .clk      (scan_clk),
    .rst_n    (rst_n),
    .apply    (apply),
    .cmd_sel  (cmd_sel),
    .cmd_dir  (cmd_dir),
    .tap_fb   (tap_fb),
    .tap_out  (tap_out)
  );

endmodule

// File: rtl/phstep_chk.sv
module phstep_chk #(
  parameter int NUM_OUT = 10,
  parameter int TAP_W   = 3,
  parameter int SETTLE  = 2
) (
  input logic                     scan_clk,
  input logic                     rst_n,
  input logic                     step_req,
  input logic                     done,
  input logic [TAP_W-1:0]         tap_fb,
  input logic [NUM_OUT*TAP_W-1:0] tap_out
);

  AST_TAP_MOVES_AT_DONE_RISE: assert property (@(posedge scan_clk) disable iff (!rst_n)
    ((tap_fb != $past(tap_fb)) || (tap_out != $past(tap_out))) |-> $rose(done)); // R8

  AST_FB_SINGLE_STEP: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (tap_fb != $past(tap_fb)) |->
      (((tap_fb - $past(tap_fb)) == TAP_W'(1)) || (($past(tap_fb) - tap_fb) == TAP_W'(1)))); // R6

  AST_FB_OUT_EXCLUSIVE: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (tap_fb != $past(tap_fb)) |-> (tap_out == $past(tap_out))); // R2

  AST_BUSY_NEEDS_REQ: assert property (@(posedge scan_clk) disable iff (!rst_n)
    $fell(done) |-> $past(step_req, 2)); // R7

  if (SETTLE >= 2) begin : g_hold
    AST_BUSY_HOLDS: assert property (@(posedge scan_clk) disable iff (!rst_n)
      $fell(done) |=> !done); // R8
  end

endmodule

bind phase_step_ctrl phstep_chk #(
  .NUM_OUT (NUM_OUT),
  .TAP_W   (TAP_W),
  .SETTLE  (SETTLE)
) u_chk (
  .scan_clk (scan_clk),
  .rst_n    (rst_n),
  .step_req (step_req),
  .done     (done),
  .tap_fb   (tap_fb),
  .tap_out  (tap_out)
);

// File: tb/phase_step_ctrl_test.sv
module phase_step_ctrl_test;

  localparam int NOUT   = 10;
  localparam int SETTLE = 2;

  logic        scan_clk;
  logic        rst_n;
  logic [3:0]  cnt_sel;
  logic        step_dir;
  logic        step_req;
  logic        done;
  logic [2:0]  tap_fb;
  logic [29:0] tap_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R1";

  phase_step_ctrl uut (
    .scan_clk (scan_clk),
    .rst_n    (rst_n),
    .cnt_sel  (cnt_sel),
    .step_dir (step_dir),
    .step_req (step_req),
    .done     (done),
    .tap_fb   (tap_fb),
    .tap_out  (tap_out)
  );

  initial scan_clk = 1'b0;
  always #5 scan_clk = ~scan_clk;

  // Behavioural reference: index 0 = feedback, 1..10 = output 0..9
  int m_tap[NOUT+1];
  int m_req_now = 0, m_req_old = 0, m_sel = 0, m_dir = 0;
  int m_left = 0, m_csel = 0, m_cdir = 0;

  function automatic int wrap8(int v);
    return (v % 8 + 8) % 8;
  endfunction

  always @(posedge scan_clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_tap[j]) m_tap[j] = 0;
      m_req_now = 0; m_req_old = 0; m_sel = 0; m_dir = 0; m_left = 0;
    end else begin
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          int d;
          d = m_cdir ? 1 : -1;
          if (m_csel == 1) m_tap[0] = wrap8(m_tap[0] + d);
          else if (m_csel == 0) for (int j = 1; j <= NOUT; j++) m_tap[j] = wrap8(m_tap[j] + d);
          else if (m_csel <= NOUT + 1) m_tap[m_csel - 1] = wrap8(m_tap[m_csel - 1] + d);
        end
      end else if (m_req_now == 1 && m_req_old == 0) begin
        m_left = SETTLE; m_csel = m_sel; m_cdir = m_dir;
      end
      m_req_old = m_req_now;
      m_req_now = int'(step_req);
      m_sel = int'(cnt_sel);
      m_dir = int'(step_dir);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare with the model on every falling edge
  always @(negedge scan_clk) begin
    chk({phase, " done"}, int'(done), (m_left == 0) ? 1 : 0);
    chk({phase, " tap_fb"}, int'(tap_fb), m_tap[0]);
    for (int j = 0; j < NOUT; j++)
      chk({phase, " tap_out"}, int'(tap_out[j*3 +: 3]), m_tap[j+1]);
  end

  function automatic int otap(int i);
    return int'(tap_out[i*3 +: 3]);
  endfunction

  task automatic step(int sel, int dir);
    @(negedge scan_clk);
    cnt_sel = 4'(sel); step_dir = dir[0]; step_req = 1'b1;
    @(negedge scan_clk);
    step_req = 1'b0;
    repeat (SETTLE + 4) @(negedge scan_clk);
  endtask

  initial begin
    rst_n = 1'b0; cnt_sel = 4'd0; step_dir = 1'b0; step_req = 1'b0;
    repeat (3) @(negedge scan_clk);
    chk("R1 done in reset", int'(done), 1);
    chk("R1 taps in reset", int'(tap_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge scan_clk);
    chk("R1 fb after reset", int'(tap_fb), 0);

    phase = "R2"; step(1, 1);
    chk("R2 fb up", int'(tap_fb), 1);
    chk("R2 outputs untouched", int'(tap_out), 0);

    phase = "R3"; step(2, 0);
    chk("R3 R6 C0 wraps down", otap(0), 7);
    step(11, 1); step(11, 1);
    chk("R3 C9 up twice", otap(9), 2);
    chk("R3 fb unchanged", int'(tap_fb), 1);

    phase = "R4"; step(0, 1);
    chk("R4 R6 C0 wraps up", otap(0), 0);
    chk("R4 C9", otap(9), 3);
    chk("R4 C5", otap(5), 1);
    chk("R4 fb unchanged", int'(tap_fb), 1);

    phase = "R5"; step(13, 1); step(15, 0); step(12, 1);
    chk("R5 fb unchanged", int'(tap_fb), 1);
    chk("R5 C4 unchanged", otap(4), 1);

    phase = "R7";
    @(negedge scan_clk); cnt_sel = 4'd1; step_dir = 1'b1; step_req = 1'b1;
    repeat (12) @(negedge scan_clk);
    step_req = 1'b0;
    repeat (4) @(negedge scan_clk);
    chk("R7 held strobe one step", int'(tap_fb), 2);

    phase = "R9";
    @(negedge scan_clk); cnt_sel = 4'd1; step_dir = 1'b1; step_req = 1'b1;
    @(negedge scan_clk); step_req = 1'b0; cnt_sel = 4'd5;
    @(negedge scan_clk); step_req = 1'b1;
    @(negedge scan_clk); step_req = 1'b0;
    repeat (SETTLE + 6) @(negedge scan_clk);
    chk("R9 fb stepped once", int'(tap_fb), 3);
    chk("R9 C3 ignored", otap(3), 1);

    phase = "R10";
    @(negedge scan_clk); cnt_sel = 4'd1; step_dir = 1'b1; step_req = 1'b1;
    @(negedge scan_clk); cnt_sel = 4'd3; step_dir = 1'b0;
    repeat (SETTLE + 4) @(negedge scan_clk);
    step_req = 1'b0;
    repeat (3) @(negedge scan_clk);
    chk("R10 fb used first select", int'(tap_fb), 4);
    chk("R10 C1 untouched", otap(1), 1);

    phase = "R8";
    @(negedge scan_clk); cnt_sel = 4'd4; step_dir = 1'b1; step_req = 1'b1;
    @(negedge scan_clk); step_req = 1'b0;        // after edge k
    chk("R8 done after k", int'(done), 1);
    @(negedge scan_clk);                         // after k+1
    chk("R8 done low after k+1", int'(done), 0);
    @(negedge scan_clk);                         // after k+2
    chk("R8 done low after k+2", int'(done), 0);
    chk("R8 C2 not yet", otap(2), 1);
    @(negedge scan_clk);                         // after k+3
    chk("R8 done back", int'(done), 1);
    chk("R8 C2 updated", otap(2), 2);
    repeat (3) @(negedge scan_clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge scan_clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule